// File: doc/BRIEF.md
# Masked BCD alarm comparator

This block watches a running calendar held in BCD and raises an alarm when the programmed alarm word agrees with it. The comparison is made only on the cycle where the one-per-second calendar strobe `tick` is high, so a matching second produces exactly one set event. Every field of the alarm word carries its own ignore bit. The day field can be compared against either the day of the month or the weekday. Hours are always compared in 24-hour form.

Software reaches the block through a small word-wide register bus with four addresses: the alarm word, a control register, a status register and a clear register. The alarm word is write-protected. It can be changed only while a write-allowed status bit is high. That bit falls as soon as the alarm is armed, and it rises a fixed number of clock cycles after the alarm is disarmed. A parameter selects between two ways of clearing the alarm flag. The interrupt output is the flag gated by an interrupt enable bit.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, the alarm word (address 0) and the control register (address 1) read 0. The status register (address 2) reads 0x1, which means write-allowed is high and the flag is low. `irq` is 0.
- R2: A write to address 0 updates the alarm word only when write-allowed (status bit 0) is 1. Otherwise the write is ignored, and a read of address 0 still returns the old word.
- R3: Write-allowed falls on the clock edge that stores a control write with the enable bit (bit 8) set to 1. It rises exactly ARM_DELAY cycles after the edge that stores a control write clearing an enable bit that was 1.
- R4: On a cycle with `tick` high and the enable bit set, the flag (status bit 8) is set when every unmasked field matches. Without `tick`, with a mismatch, or with the enable bit at 0, the flag is not set.
- R5: The alarm word keeps seconds in bits 6:0, minutes in 14:8, hours in 21:16 and the day in 29:24. A set bit at 7, 15, 23 or 31 removes the seconds, minutes, hours or day field from the comparison.
- R6: When bit 30 is 1, bits 27:24 are compared with the weekday (1 to 7). When bit 30 is 0, bits 29:24 are compared with the BCD day of the month.
- R7: Bit 22 (the PM bit) must be 0 for the hours field to match while the hours field is unmasked.
- R8: With CLR_BY_ONE=0, a write to address 2 with bit 8 at 0 clears the flag. A write there with bit 8 at 1 leaves the flag unchanged, and writes to address 3 do not affect the flag.
- R9: With CLR_BY_ONE=1, a write to address 3 with bit 8 at 1 clears the flag. Writes to address 2 do not affect the flag.
- R10: When an alarm match and a flag-clear write fall in the same cycle, the flag ends that cycle set.
- R11: `irq` is 1 exactly when the flag and the interrupt enable (control bit 12) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle calendar second strobe |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD, 24-hour |
| now_mday | input | 6 | Current day of month, BCD |
| now_wday | input | 3 | Current weekday, 1 to 7 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq | output | 1 | Alarm interrupt |

## Verification
Two events can land in the same cycle: an alarm match that sets the flag, and a bus write that clears it. The bench provokes this by driving a matching `tick` and a clearing write in the same cycle, once for each clear style. It then judges the result by reading the status register on the next half cycle, where the flag must still be set. Two instances, one per clear style, receive identical stimulus, so a write that clears the flag in one instance has to leave the flag untouched in the other.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int DW      = 32;
    localparam int AW      = 2;
    localparam int N_FIELD = 4;
    localparam int FIELD_W = 7;

    localparam logic [AW-1:0] REG_WORD = 2'd0;
    localparam logic [AW-1:0] REG_CTRL = 2'd1;
    localparam logic [AW-1:0] REG_STAT = 2'd2;
    localparam logic [AW-1:0] REG_CLR  = 2'd3;

    localparam int CTRL_EN_BIT   = 8;
    localparam int CTRL_IE_BIT   = 12;
    localparam int STAT_WAF_BIT  = 0;
    localparam int STAT_FLAG_BIT = 8;

    typedef enum int {F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DAY = 3} field_e;

    typedef struct packed {
        logic       day_ign;
        logic       by_wday;
        logic [5:0] day;
        logic       hr_ign;
        logic       pm;
        logic [5:0] hr;
        logic       min_ign;
        logic [6:0] min;
        logic       sec_ign;
        logic [6:0] sec;
    } alm_word_t;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hr;
        logic [5:0] mday;
        logic [2:0] wday;
    } cal_now_t;

    function automatic logic [FIELD_W-1:0] widen6(input logic [5:0] v);
        return {1'b0, v};
    endfunction

endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
    parameter int W = 7
) (
    input  logic [W-1:0] want,
    input  logic [W-1:0] have,
    input  logic         ign,
    output logic         hit
);
    always_comb hit = ign || (want == have);
endmodule

// File: rtl/alm_arm_ctl.sv
module alm_arm_ctl #(
    parameter int ARM_DELAY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic wr_en_bit,
    input  logic wr_ie_bit,
    output logic en_q,
    output logic ie_q,
    output logic waf_q
);
    localparam int CW = $clog2(ARM_DELAY + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            ie_q  <= 1'b0;
            waf_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            if (ctrl_wr) ie_q <= wr_ie_bit;
            if (ctrl_wr && wr_en_bit) begin
                en_q  <= 1'b1;
                waf_q <= 1'b0;
                cnt_q <= '0;
            end else if (ctrl_wr && !wr_en_bit && en_q) begin
                en_q  <= 1'b0;
                cnt_q <= CW'(ARM_DELAY);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) waf_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/alm_flag_ctl.sv
module alm_flag_ctl #(
    parameter bit CLR_BY_ONE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic stat_wr,
    input  logic stat_flag_bit,
    input  logic clr_wr,
    input  logic clr_flag_bit,
    output logic flag_q
);
    logic clr_req;

    always_comb begin
        if (CLR_BY_ONE) clr_req = clr_wr && clr_flag_bit;
        else            clr_req = stat_wr && !stat_flag_bit;
    end

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (set_req) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alm_pkg::*;
#(
    parameter int ARM_DELAY  = 2,
    parameter bit CLR_BY_ONE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [6:0]    now_sec,
    input  logic [6:0]    now_min,
    input  logic [5:0]    now_hour,
    input  logic [5:0]    now_mday,
    input  logic [2:0]    now_wday,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    alm_word_t word_q;
    cal_now_t  now;
    logic en_q, ie_q, waf_q, flag_q;
    logic word_wr, ctrl_wr, stat_wr, clr_wr;
    logic all_hit, set_req;

    logic [FIELD_W-1:0] want [N_FIELD];
    logic [FIELD_W-1:0] have [N_FIELD];
    logic               ign  [N_FIELD];
    logic [N_FIELD-1:0] hit;

    always_comb begin
        now.sec  = now_sec;
        now.min  = now_min;
        now.hr   = now_hour;
        now.mday = now_mday;
        now.wday = now_wday;
    end

    always_comb begin
        word_wr = bus_wr && (bus_addr == REG_WORD);
        ctrl_wr = bus_wr && (bus_addr == REG_CTRL);
        stat_wr = bus_wr && (bus_addr == REG_STAT);
        clr_wr  = bus_wr && (bus_addr == REG_CLR);
    end

    always_ff @(posedge clk) begin
        if (rst)                  word_q <= '0;
        else if (word_wr && waf_q) word_q <= alm_word_t'(bus_wdata);
    end

    always_comb begin
        want[F_SEC]  = word_q.sec;
        have[F_SEC]  = now.sec;
        ign[F_SEC]   = word_q.sec_ign;
        want[F_MIN]  = word_q.min;
        have[F_MIN]  = now.min;
        ign[F_MIN]   = word_q.min_ign;
        want[F_HOUR] = {word_q.pm, word_q.hr};
        have[F_HOUR] = widen6(now.hr);
        ign[F_HOUR]  = word_q.hr_ign;
        if (word_q.by_wday) begin
            want[F_DAY] = {3'b000, word_q.day[3:0]};
            have[F_DAY] = {4'b0000, now.wday};
        end else begin
            want[F_DAY] = widen6(word_q.day);
            have[F_DAY] = widen6(now.mday);
        end
        ign[F_DAY] = word_q.day_ign;
    end

    for (genvar g = 0; g < N_FIELD; g++) begin : g_cmp
        alm_field_cmp #(.W(FIELD_W)) u_cmp (
            .want (want[g]),
            .have (have[g]),
            .ign  (ign[g]),
            .hit  (hit[g])
        );
    end

    always_comb begin
        all_hit = &hit;
        set_req = tick && en_q && all_hit;
    end

    alm_arm_ctl #(.ARM_DELAY(ARM_DELAY)) u_arm (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .wr_en_bit (bus_wdata[CTRL_EN_BIT]),
        .wr_ie_bit (bus_wdata[CTRL_IE_BIT]),
        .en_q      (en_q),
        .ie_q      (ie_q),
        .waf_q     (waf_q)
    );

    alm_flag_ctl #(.CLR_BY_ONE(CLR_BY_ONE)) u_flag (
        .clk           (clk),
        .rst           (rst),
        .set_req       (set_req),
        .stat_wr       (stat_wr),
        .stat_flag_bit (bus_wdata[STAT_FLAG_BIT]),
        .clr_wr        (clr_wr),
        .clr_flag_bit  (bus_wdata[STAT_FLAG_BIT]),
        .flag_q        (flag_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_WORD: bus_rdata = word_q;
            REG_CTRL: begin
                bus_rdata[CTRL_EN_BIT] = en_q;
                bus_rdata[CTRL_IE_BIT] = ie_q;
            end
            REG_STAT: begin
                bus_rdata[STAT_WAF_BIT]  = waf_q;
                bus_rdata[STAT_FLAG_BIT] = flag_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    always_comb irq = flag_q && ie_q;

endmodule

// File: rtl/alm_match_chk.sv
module alm_match_chk
    import alm_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      tick,
    input logic      en_q,
    input logic      waf_q,
    input logic      flag_q,
    input logic      all_hit,
    input alm_word_t word_q
);
    a_r3_waf_drops_on_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> !waf_q);

    a_r3_waf_rises_disarmed: assert property (@(posedge clk) disable iff (rst)
        $rose(waf_q) |-> !en_q);

    a_r2_word_locked: assert property (@(posedge clk) disable iff (rst)
        !waf_q |=> $stable(word_q));

    a_r4_flag_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(tick && en_q));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (tick && en_q && all_hit) |=> flag_q);
endmodule

bind alarm_match_unit alm_match_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .en_q    (en_q),
    .waf_q   (waf_q),
    .flag_q  (flag_q),
    .all_hit (all_hit),
    .word_q  (word_q)
);

// File: tb/alarm_match_unit_test.sv
module alarm_match_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [6:0]  now_sec = '0, now_min = '0;
    logic [5:0]  now_hour = '0, now_mday = '0;
    logic [2:0]  now_wday = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd0, rd1;
    logic        irq0, irq1;
    logic        done = 1'b0;
    int          checks = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_match_unit #(.ARM_DELAY(2), .CLR_BY_ONE(1'b0)) uut (
        .clk(clk), .rst(rst), .tick(tick), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_mday(now_mday), .now_wday(now_wday),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd0), .irq(irq0));

    alarm_match_unit #(.ARM_DELAY(2), .CLR_BY_ONE(1'b1)) uut1 (
        .clk(clk), .rst(rst), .tick(tick), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_mday(now_mday), .now_wday(now_wday),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd1), .irq(irq1));

    typedef struct {
        string       tag;
        logic [31:0] e0;
        logic [31:0] e1;
        logic        i0;
        logic        i1;
    } item_t;

    item_t sb_q[$];
    event  smp;

    task automatic cmp(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            item_t it;
            @(smp);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                cmp(it.tag, "rdata0", rd0, it.e0);
                cmp(it.tag, "rdata1", rd1, it.e1);
                cmp(it.tag, "irq0", {31'b0, irq0}, {31'b0, it.i0});
                cmp(it.tag, "irq1", {31'b0, irq1}, {31'b0, it.i1});
            end
        end
    end

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [31:0] e0,
                              input logic [31:0] e1, input logic i0, input logic i1);
        bus_addr = a;
        #1;
        sb_q.push_back('{tag, e0, e1, i0, i1});
        ->smp;
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_now(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                           input logic [5:0] d, input logic [2:0] w);
        now_sec = s; now_min = m; now_hour = h; now_mday = d; now_wday = w;
    endtask

    task automatic disarm();
        wr(2'd1, 32'h0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_both();
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h100);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_reg("R1 reset status", 2'd2, 32'h1, 32'h1, 1'b0, 1'b0);
        expect_reg("R1 reset ctrl",   2'd1, 32'h0, 32'h0, 1'b0, 1'b0);
        expect_reg("R1 reset word",   2'd0, 32'h0, 32'h0, 1'b0, 1'b0);

        wr(2'd0, 32'h12081530);
        expect_reg("R2 write allowed", 2'd0, 32'h12081530, 32'h12081530, 1'b0, 1'b0);
        wr(2'd1, 32'h1100);
        expect_reg("R3 waf drops on arm", 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
        wr(2'd0, 32'hFFFFFFFF);
        expect_reg("R2 locked write ignored", 2'd0, 32'h12081530, 32'h12081530, 1'b0, 1'b0);

        set_now(7'h31, 7'h15, 6'h08, 6'h12, 3'd3);
        pulse_tick();
        expect_reg("R4 mismatch", 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
        set_now(7'h30, 7'h15, 6'h08, 6'h12, 3'd3);
        repeat (3) @(negedge clk);
        expect_reg("R4 no tick", 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
        pulse_tick();
        expect_reg("R4 R11 match sets flag", 2'd2, 32'h100, 32'h100, 1'b1, 1'b1);

        wr(2'd3, 32'h100);
        expect_reg("R8 R9 clear register", 2'd2, 32'h100, 32'h0, 1'b1, 1'b0);
        wr(2'd2, 32'h100);
        expect_reg("R8 status bit one keeps", 2'd2, 32'h100, 32'h0, 1'b1, 1'b0);
        pulse_tick();
        expect_reg("R4 set again", 2'd2, 32'h100, 32'h100, 1'b1, 1'b1);
        wr(2'd2, 32'h0);
        expect_reg("R8 R9 status write zero", 2'd2, 32'h0, 32'h100, 1'b0, 1'b1);
        wr(2'd3, 32'h100);
        expect_reg("R9 clear by one", 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);

        wr(2'd1, 32'h0100);
        pulse_tick();
        expect_reg("R11 irq masked", 2'd2, 32'h100, 32'h100, 1'b0, 1'b0);
        wr(2'd1, 32'h1100);
        expect_reg("R11 irq unmasked", 2'd2, 32'h100, 32'h100, 1'b1, 1'b1);
        clear_both();

        wr(2'd1, 32'h0);
        expect_reg("R3 waf low edge 0", 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        expect_reg("R3 waf low edge 1", 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        expect_reg("R3 waf high edge 2", 2'd2, 32'h1, 32'h1, 1'b0, 1'b0);
        pulse_tick();
        expect_reg("R4 disabled no flag", 2'd2, 32'h1, 32'h1, 1'b0, 1'b0);

        wr(2'd0, 32'h12088080);
        wr(2'd1, 32'h1100);
        set_now(7'h07, 7'h42, 6'h09, 6'h12, 3'd3);
        pulse_tick();
        expect_reg("R5 unmasked hour differs", 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
        set_now(7'h07, 7'h42, 6'h08, 6'h12, 3'd3);
        pulse_tick();
        expect_reg("R5 masked sec min", 2'd2, 32'h100, 32'h100, 1'b1, 1'b1);
        clear_both();

        disarm();
        wr(2'd0, 32'h45801530);
        wr(2'd1, 32'h1100);
        set_now(7'h30, 7'h15, 6'h23, 6'h20, 3'd4);
        pulse_tick();
        expect_reg("R6 weekday differs", 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
        set_now(7'h30, 7'h15, 6'h23, 6'h20, 3'd5);
        pulse_tick();
        expect_reg("R6 weekday match", 2'd2, 32'h100, 32'h100, 1'b1, 1'b1);
        clear_both();

        disarm();
        wr(2'd0, 32'h80081530);
        wr(2'd1, 32'h1100);
        set_now(7'h30, 7'h15, 6'h08, 6'h27, 3'd1);
        pulse_tick();
        expect_reg("R5 day masked", 2'd2, 32'h100, 32'h100, 1'b1, 1'b1);
        clear_both();

        disarm();
        wr(2'd0, 32'h12481530);
        wr(2'd1, 32'h1100);
        set_now(7'h30, 7'h15, 6'h08, 6'h12, 3'd3);
        pulse_tick();
        expect_reg("R7 pm bit blocks", 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);

        disarm();
        wr(2'd0, 32'h80081530);
        wr(2'd1, 32'h1100);
        tick_wr(2'd2, 32'h0);
        expect_reg("R10 set beats status clear", 2'd2, 32'h100, 32'h100, 1'b1, 1'b1);
        tick_wr(2'd3, 32'h100);
        expect_reg("R10 set beats clear register", 2'd2, 32'h100, 32'h100, 1'b1, 1'b1);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule